// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a binary up-counter built from identical 4-bit slices that are chained by look-ahead carry. Every state bit of every slice is clocked from one clock and changes only on its rising edge, so the count never shows intermediate ripple values. The width comes from two parameters: the bits per slice and the number of slices.

Four controls set the counter's behaviour, in a fixed priority. An active-low clear acts at once, without waiting for the clock, and forces the count to zero. An active-low load copies the preset word into the count on the next rising edge, whatever the enables are doing. Two count enables with different roles come next. The counter advances only when both are high. The "chain" enable also gates the carry output, so a higher slice, or another whole counter, can take that carry as its own chain enable with no extra gating. When load is inactive and either enable is low, the count holds.

Inside the wrapper, each slice's carry drives the next slice's chain enable. Every slice's gating enable is driven from the common input. The chain as a whole behaves as one wide counter. All pins are plain control and data levels with no handshake. The preset is sampled only on a rising edge while load is active, and the count is a registered level that is always valid.

Top module: `cascade_counter`

## Requirements
- R1: While clr_n is 0 the count is 0, with no clock edge needed. Clear overrides load and both enables.
- R2: When clr_n is 1 and load_n is 0 at a rising edge, count takes the value of preset, whatever en_p and en_t are.
- R3: When clr_n, load_n, en_p and en_t are all 1 at a rising edge, count becomes count + 1 modulo 2^W.
- R4: When clr_n and load_n are 1 and en_p or en_t is 0 at a rising edge, count keeps its value.
- R5: An increment from the all-ones value gives zero. A 4-bit slice preset to 12 counts 13, 14, 15, 0, 1, 2.
- R6: carry_out is 1 exactly when en_t is 1 and count is all ones. It follows these two combinationally within the same cycle and does not depend on en_p.
- R7: With several slices, carries move across slice boundaries within a single edge. For example, 8'h0F counts to 8'h10 and 8'hFF counts to 8'h00, so the chain acts as one W-bit counter.
- R8: Between rising edges, count changes only when clr_n falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Gating count enable, common to all slices |
| en_t | input | 1 | Chain count enable; also gates carry_out |
| preset | input | W (STAGES*STAGE_W) | Value loaded when load_n is low |
| count | output | W | Current count |
| carry_out | output | 1 | Look-ahead carry for the next counter |

## Verification
The bound checker follows the priority chain on every rising edge. It checks that a clear holds the count at zero, that a load takes the preset, that a full enable increments, and that every other case holds the value. It also checks that carry_out always equals en_t ANDed with an all-ones count. The bench's scenarios are needed for the rest. These include the clear taking effect between edges, the exact 12 to 2 wrap sequence of a lone slice, and carries crossing slice boundaries at 8'h0F and 8'hFF. They also include carry_out staying high at all ones while en_p is low, and the count staying still between edges.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2
  } ctr_op_e;

  // Synchronous priority: load first, then count, otherwise hold
  function automatic ctr_op_e pick_op(input logic load_n,
                                      input logic en_p,
                                      input logic en_t);
    if (!load_n)           return OP_LOAD;
    else if (en_p && en_t) return OP_COUNT;
    else                   return OP_HOLD;
  endfunction

endpackage

// File: rtl/ctr_ctl.sv
module ctr_ctl
  import cascade_counter_pkg::*;
(
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output ctr_op_e op
);
  always_comb op = pick_op(load_n, en_p, en_t);
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
  import cascade_counter_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          en_p,
  input  logic          en_t,
  input  logic [SW-1:0] din,
  output logic [SW-1:0] q,
  output logic          rco
);
  localparam logic [SW-1:0] ONE = SW'(1);

  ctr_op_e op;

  ctr_ctl u_ctl (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_LOAD:  q <= din;
        OP_COUNT: q <= q + ONE;
        default:  q <= q;
      endcase
    end
  end

  // Look-ahead carry: chain enable fed forward, gating enable excluded
  assign rco = en_t & (&q);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGES  = 2,
  parameter int STAGE_W = 4
) (
  input  logic                       clk,
  input  logic                       clr_n,
  input  logic                       load_n,
  input  logic                       en_p,
  input  logic                       en_t,
  input  logic [STAGES*STAGE_W-1:0]  preset,
  output logic [STAGES*STAGE_W-1:0]  count,
  output logic                       carry_out
);
  localparam int W = STAGES * STAGE_W;

  logic [STAGES:0] t_chain;

  assign t_chain[0] = en_t;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    ctr_stage #(.SW(STAGE_W)) u_stage (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_p),
      .en_t   (t_chain[g]),
      .din    (preset[g*STAGE_W +: STAGE_W]),
      .q      (count[g*STAGE_W +: STAGE_W]),
      .rco    (t_chain[g+1])
    );
  end

  assign carry_out = t_chain[STAGES];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] preset,
  input logic [W-1:0] count,
  input logic         carry_out
);
  localparam logic [W-1:0] ONE = W'(1);

  // R1: clear dominates every other control
  always @(posedge clk) begin
    if (clr_n === 1'b0) begin
      p_clear_zero_r1: assert (count == '0)
        else $error("clear did not zero the count");
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(preset));

  p_count_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t) |=> count == $past(count) + ONE);

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(count));

  p_carry_r6: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out == (en_t && (count == {W{1'b1}})));
endmodule

bind cascade_counter cascade_counter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .en_p      (en_p),
  .en_t      (en_t),
  .preset    (preset),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/cascade_counter_tb.sv
`timescale 1ns/1ps
module cascade_counter_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clr_n, load_n, en_p, en_t;
  logic [W-1:0] preset;
  logic [W-1:0] count;
  logic carry_out;

  logic load4_n, p4, t4;
  logic [3:0] pre4, cnt4;
  logic carry4;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_cnt;
  logic done = 1'b0;

  always #10 clk = ~clk;

  cascade_counter #(.STAGES(2), .STAGE_W(4)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .preset(preset), .count(count), .carry_out(carry_out)
  );

  cascade_counter #(.STAGES(1), .STAGE_W(4)) u_dut4 (
    .clk(clk), .clr_n(clr_n), .load_n(load4_n), .en_p(p4), .en_t(t4),
    .preset(pre4), .count(cnt4), .carry_out(carry4)
  );

  function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic ld_n,
                                              logic p, logic t, logic [W-1:0] d);
    if (!ld_n)      return d;
    else if (p && t) return cur + 1'b1;
    else            return cur;
  endfunction

  function automatic string op_tag(logic ld_n, logic p, logic t);
    if (!ld_n)       return "R2";
    else if (p && t) return "R3";
    else             return "R4";
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  string last_tag = "R1";

  // One cycle: check count at negedge, drive, check carry, advance model
  task automatic cycle(logic ld_n, logic p, logic t, logic [W-1:0] d);
    @(negedge clk);
    check(last_tag, count, exp_cnt);
    load_n = ld_n; en_p = p; en_t = t; preset = d;
    #1;
    check("R6", {7'd0, carry_out}, {7'd0, t && (exp_cnt == 8'hFF)});
    if (p && t && ld_n && exp_cnt == 8'hFF) last_tag = "R5";
    else if (p && t && ld_n && exp_cnt[3:0] == 4'hF) last_tag = "R7";
    else last_tag = op_tag(ld_n, p, t);
    exp_cnt = model_next(exp_cnt, ld_n, p, t, d);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    clr_n = 0; load_n = 1; en_p = 0; en_t = 0; preset = '0;
    load4_n = 1; p4 = 0; t4 = 0; pre4 = '0;
    exp_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", count, 8'h00);
    check("R1 reset4", {4'd0, cnt4}, 8'h00);
    clr_n = 1;

    // R2: load wins over disabled and enabled counting
    cycle(0, 0, 0, 8'hA5);
    cycle(0, 1, 1, 8'h0F);
    // R7: carry crosses the slice boundary 0F -> 10
    cycle(1, 1, 1, 8'h00);
    cycle(1, 1, 1, 8'h00);
    // R6 with en_p low at all ones, then R5 full-width wrap
    cycle(0, 1, 1, 8'hFF);
    cycle(1, 0, 1, 8'h00);
    cycle(1, 1, 0, 8'h00);
    cycle(1, 1, 1, 8'h00);
    cycle(1, 1, 1, 8'h00);

    // R8: count stays still between edges
    @(negedge clk);
    check(last_tag, count, exp_cnt);
    last_tag = "R8";
    load_n = 1; en_p = 0; en_t = 0;
    #3 check("R8", count, exp_cnt);
    #3 check("R8", count, exp_cnt);

    // R1: asynchronous clear mid-cycle, ahead of load
    load_n = 0; preset = 8'h77; en_p = 1; en_t = 1;
    #2 clr_n = 0;
    #1 check("R1 async", count, 8'h00);
    exp_cnt = '0;
    @(posedge clk); #1;
    check("R1 over load", count, 8'h00);
    @(negedge clk); clr_n = 1; load_n = 1; en_p = 0; en_t = 0;
    last_tag = "R4";

    // Constrained random traffic
    for (int i = 0; i < 600; i++) begin
      logic ld_n, p, t;
      logic [W-1:0] d;
      ld_n = ($urandom % 8) != 0;
      p = ($urandom % 4) != 0;
      t = ($urandom % 4) != 0;
      d = W'($urandom);
      if (($urandom % 16) == 0) d = 8'hFE;
      cycle(ld_n, p, t, d);
    end
    @(negedge clk);
    check(last_tag, count, exp_cnt);

    // R5: single slice preset 12 then 13,14,15,0,1,2, then inhibit
    load4_n = 0; pre4 = 4'd12; p4 = 0; t4 = 0;
    @(negedge clk);
    check("R2 slice", {4'd0, cnt4}, 8'd12);
    load4_n = 1; p4 = 1; t4 = 1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check("R5 slice", {4'd0, cnt4}, 8'((12 + k) % 16));
    end
    p4 = 0;
    @(negedge clk);
    check("R4 slice", {4'd0, cnt4}, 8'd2);
    t4 = 1; load4_n = 0; pre4 = 4'hF;
    @(negedge clk);
    load4_n = 1; p4 = 0;
    #1 check("R6 slice", {7'd0, carry4}, 8'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule